// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block drives the two closing sequences of an I2C master byte transfer. One sends the acknowledge bit after a received byte. The other generates a Stop condition. It controls the bus only through two pull-low enables, one for SCL and one for SDA. It watches the sampled line levels so that a slave stretching the clock only lengthens a phase. It never corrupts a phase. Every timed phase lasts one period of a reloadable baud down-counter, and the period length is set by `baud_reload`.

Software starts a sequence with a one-cycle request pulse. While a sequence runs, a status bit shows that it is active, and that bit clears itself when the sequence completes. Completion raises a sticky interrupt flag. A write to the byte buffer while a sequence runs is refused, and a sticky collision flag is raised instead. A status bit records that the Stop condition was seen on the bus.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `irq_flag`, `wcol_flag`, `stop_seen`, `ack_active` and `stop_active` are all 0, and `buf_rdata` is 0.
- R2: An `ack_req` pulse while idle sets `ack_active`, `scl_pull` and `sda_pull = ~ack_bit` on the next clock edge. An `ack_bit` of 0 gives an ACK (SDA pulled low), and 1 gives a NACK (SDA released).
- R3: In an acknowledge, SCL is held low for N cycles and then released. N is `baud_reload`, or 1 when `baud_reload` is 0. The block waits until `scl_in` is high, then counts N more cycles before it pulls SCL low again. For an ACK with S stretch cycles, the SDA pull lasts 2N+1+S cycles.
- R4: At the end of an acknowledge, `ack_active` clears, `irq_flag` sets, `sda_pull` releases and `scl_pull` stays asserted.
- R5: A `stop_req` pulse while idle sets `stop_active` and asserts both pulls. The block waits until `sda_in` is low, counts N cycles, then releases SCL.
- R6: After `scl_in` reads high, the block counts N cycles and then releases SDA. When both lines read high, `stop_seen` sets. N cycles later, `stop_active` clears and `irq_flag` sets. With no stretching, `stop_seen` appears 2N+3 edges after the request edge and `stop_active` clears 3N+3 edges after it. The SDA pull lasts 2N+2+S cycles.
- R7: A `buf_wr` while idle loads `buf_wdata` into `buf_rdata`. A `buf_wr` while a sequence is active sets `wcol_flag` and leaves `buf_rdata` unchanged.
- R8: `irq_flag` stays set until an `irq_clr` pulse, and `wcol_flag` stays set until a `wcol_clr` pulse. `stop_seen` clears when any new sequence starts.
- R9: When `ack_req` and `stop_req` arrive in the same idle cycle, the acknowledge wins. Any request that arrives while a sequence is active is ignored.
- R10: A `baud_reload` of 0 behaves as a one-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Pulse that starts an acknowledge sequence |
| ack_bit | input | 1 | Acknowledge value to send: 0 for ACK, 1 for NACK |
| stop_req | input | 1 | Pulse that starts a Stop sequence |
| buf_wr | input | 1 | Write strobe for the byte buffer |
| buf_wdata | input | DATA_W | Data to write into the byte buffer |
| buf_rdata | output | DATA_W | Current contents of the byte buffer |
| irq_clr | input | 1 | Pulse that clears `irq_flag` |
| wcol_clr | input | 1 | Pulse that clears `wcol_flag` |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| baud_reload | input | BAUD_W | Length of one baud period in clocks (0 is treated as 1) |
| scl_pull | output | 1 | Pulls SCL low when 1 |
| sda_pull | output | 1 | Pulls SDA low when 1 |
| ack_active | output | 1 | Acknowledge sequence in progress |
| stop_active | output | 1 | Stop sequence in progress |
| irq_flag | output | 1 | Sticky flag set when a sequence completes |
| wcol_flag | output | 1 | Sticky flag set by a refused buffer write |
| stop_seen | output | 1 | Stop condition observed on the bus |

## Verification
The bench models the open-drain bus and a slave that stretches the clock after SCL is released. A sequencer that counted blindly instead of waiting for the line would give an SDA pulse that is too short by the stretch length. A scoreboard compares every SDA pulse length against the value predicted from N and the stretch count. This exposes off-by-one errors in the baud reload, a zero reload that fails to become one, and a skipped wait phase. Direct checks cover the remaining cases:
- A buffer write during a sequence must leave the buffer unchanged.
- A stop request that arrives during an acknowledge must not start a Stop afterwards.
- Two requests in the same cycle must start the acknowledge.
- The edge at which `stop_seen` appears and the edge at which `stop_active` clears must both be exact.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ACK_LOW,
        SQ_ACK_REL,
        SQ_ACK_HIGH,
        SQ_STP_SDA,
        SQ_STP_LOW,
        SQ_STP_REL,
        SQ_STP_HIGH,
        SQ_STP_WAIT,
        SQ_STP_HOLD
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       scl_pull;
        logic       sda_pull;
    } seq_regs_t;

    typedef struct packed {
        logic irq;
        logic wcol;
        logic seen;
    } flag_regs_t;

endpackage

// File: rtl/i2c_seq_baud.sv
module i2c_seq_baud #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [BAUD_W-1:0] reload,
    output logic              roll
);
    localparam logic [BAUD_W-1:0] CNT_ONE  = BAUD_W'(1);
    localparam logic [BAUD_W-1:0] CNT_ZERO = '0;

    logic [BAUD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (reload == CNT_ZERO) ? CNT_ONE : reload;
        end else if (run && cnt_q != CNT_ZERO) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    assign roll = run && (cnt_q == CNT_ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_ZERO;
        else        cnt_q <= cnt_d;
    end

    // R10
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != CNT_ZERO));

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_req,
    input  logic ack_bit,
    input  logic stop_req,
    input  logic scl_in,
    input  logic sda_in,
    input  logic roll,
    output logic load,
    output logic run,
    output logic scl_pull,
    output logic sda_pull,
    output logic ack_active,
    output logic stop_active,
    output logic seq_start,
    output logic seq_done,
    output logic seen_set
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        load      = 1'b0;
        run       = 1'b0;
        seq_start = 1'b0;
        seq_done  = 1'b0;
        seen_set  = 1'b0;
        case (r_q.state)
            SQ_IDLE: begin
                if (ack_req) begin
                    r_d.state    = SQ_ACK_LOW;
                    r_d.scl_pull = 1'b1;
                    r_d.sda_pull = ~ack_bit;
                    load         = 1'b1;
                    seq_start    = 1'b1;
                end else if (stop_req) begin
                    r_d.state    = SQ_STP_SDA;
                    r_d.scl_pull = 1'b1;
                    r_d.sda_pull = 1'b1;
                    seq_start    = 1'b1;
                end
            end
            SQ_ACK_LOW: begin
                run = 1'b1;
                if (roll) begin
                    r_d.scl_pull = 1'b0;
                    r_d.state    = SQ_ACK_REL;
                end
            end
            SQ_ACK_REL: begin
                if (scl_in) begin
                    load      = 1'b1;
                    r_d.state = SQ_ACK_HIGH;
                end
            end
            SQ_ACK_HIGH: begin
                run = 1'b1;
                if (roll) begin
                    r_d.scl_pull = 1'b1;
                    r_d.sda_pull = 1'b0;
                    r_d.state    = SQ_IDLE;
                    seq_done     = 1'b1;
                end
            end
            SQ_STP_SDA: begin
                if (!sda_in) begin
                    load      = 1'b1;
                    r_d.state = SQ_STP_LOW;
                end
            end
            SQ_STP_LOW: begin
                run = 1'b1;
                if (roll) begin
                    r_d.scl_pull = 1'b0;
                    r_d.state    = SQ_STP_REL;
                end
            end
            SQ_STP_REL: begin
                if (scl_in) begin
                    load      = 1'b1;
                    r_d.state = SQ_STP_HIGH;
                end
            end
            SQ_STP_HIGH: begin
                run = 1'b1;
                if (roll) begin
                    r_d.sda_pull = 1'b0;
                    r_d.state    = SQ_STP_WAIT;
                end
            end
            SQ_STP_WAIT: begin
                if (scl_in && sda_in) begin
                    seen_set  = 1'b1;
                    load      = 1'b1;
                    r_d.state = SQ_STP_HOLD;
                end
            end
            SQ_STP_HOLD: begin
                run = 1'b1;
                if (roll) begin
                    r_d.state = SQ_IDLE;
                    seq_done  = 1'b1;
                end
            end
            default: begin
                r_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= SQ_IDLE;
            r_q.scl_pull <= 1'b0;
            r_q.sda_pull <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_pull    = r_q.scl_pull;
    assign sda_pull    = r_q.sda_pull;
    assign ack_active  = (r_q.state == SQ_ACK_LOW) || (r_q.state == SQ_ACK_REL) ||
                         (r_q.state == SQ_ACK_HIGH);
    assign stop_active = (r_q.state == SQ_STP_SDA)  || (r_q.state == SQ_STP_LOW) ||
                         (r_q.state == SQ_STP_REL)  || (r_q.state == SQ_STP_HIGH) ||
                         (r_q.state == SQ_STP_WAIT) || (r_q.state == SQ_STP_HOLD);

    // R3
    ack_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SQ_ACK_REL && !scl_in) |=> (!r_q.scl_pull && ack_active));

    // R5
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_active) |-> (r_q.scl_pull && r_q.sda_pull));

endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags
    import i2c_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seq_done,
    input  logic collide,
    input  logic irq_clr,
    input  logic wcol_clr,
    input  logic seen_set,
    input  logic seen_clr,
    output logic irq_flag,
    output logic wcol_flag,
    output logic stop_seen
);
    flag_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (irq_clr)  f_d.irq  = 1'b0;
        if (seq_done) f_d.irq  = 1'b1;
        if (wcol_clr) f_d.wcol = 1'b0;
        if (collide)  f_d.wcol = 1'b1;
        if (seen_clr) f_d.seen = 1'b0;
        if (seen_set) f_d.seen = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign irq_flag  = f_q.irq;
    assign wcol_flag = f_q.wcol;
    assign stop_seen = f_q.seen;

    // R7
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> wcol_flag);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
    parameter int BAUD_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic              ack_bit,
    input  logic              stop_req,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BAUD_W-1:0] baud_reload,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              ack_active,
    output logic              stop_active,
    output logic              irq_flag,
    output logic              wcol_flag,
    output logic              stop_seen
);
    logic load, run, roll;
    logic seq_start, seq_done, seen_set;
    logic busy, collide;
    logic [DATA_W-1:0] buf_d, buf_q;

    i2c_seq_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .run    (run),
        .reload (baud_reload),
        .roll   (roll)
    );

    i2c_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_req     (ack_req),
        .ack_bit     (ack_bit),
        .stop_req    (stop_req),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .roll        (roll),
        .load        (load),
        .run         (run),
        .scl_pull    (scl_pull),
        .sda_pull    (sda_pull),
        .ack_active  (ack_active),
        .stop_active (stop_active),
        .seq_start   (seq_start),
        .seq_done    (seq_done),
        .seen_set    (seen_set)
    );

    assign busy    = ack_active | stop_active;
    assign collide = buf_wr & busy;

    i2c_seq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_done  (seq_done),
        .collide   (collide),
        .irq_clr   (irq_clr),
        .wcol_clr  (wcol_clr),
        .seen_set  (seen_set),
        .seen_clr  (seq_start),
        .irq_flag  (irq_flag),
        .wcol_flag (wcol_flag),
        .stop_seen (stop_seen)
    );

    always_comb begin
        buf_d = buf_q;
        if (buf_wr && !busy) buf_d = buf_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign buf_rdata = buf_q;

    // R7
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && busy) |=> $stable(buf_rdata));

    // R9
    one_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_active, stop_active}));

    // R4
    irq_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_flag);

endmodule

// File: tb/i2c_ackstop_seq_test.sv
module i2c_ackstop_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_req = 1'b0, ack_bit = 1'b0, stop_req = 1'b0;
    logic       buf_wr = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0;
    logic [7:0] buf_wdata = 8'h00, buf_rdata;
    logic [7:0] baud_reload = 8'd4;
    logic       scl_in, sda_in, scl_pull, sda_pull;
    logic       ack_active, stop_active, irq_flag, wcol_flag, stop_seen;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;
    int exp_q[$];
    int stretch_cycles = 0, hold_cnt = 0, sda_len = 0;
    logic pull_prev = 1'b0;

    always #10 clk = ~clk;

    assign scl_in = ~(scl_pull | (pull_prev && stretch_cycles > 0) | (hold_cnt > 0));
    assign sda_in = ~sda_pull;

    i2c_ackstop_seq uut (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_bit(ack_bit),
        .stop_req(stop_req), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
        .scl_in(scl_in), .sda_in(sda_in), .baud_reload(baud_reload),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .ack_active(ack_active),
        .stop_active(stop_active), .irq_flag(irq_flag), .wcol_flag(wcol_flag),
        .stop_seen(stop_seen)
    );

    // slave clock stretching model
    always @(negedge clk) begin
        if (pull_prev && !scl_pull && stretch_cycles > 0) hold_cnt = stretch_cycles;
        else if (hold_cnt > 0) hold_cnt = hold_cnt - 1;
        pull_prev = scl_pull;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: SDA pull pulse lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_pull) sda_len++;
            else if (sda_len > 0) begin
                if (exp_q.size() == 0) chk("R3/R6 unexpected SDA pulse", sda_len, 0);
                else chk("R3/R6 SDA pulse length", sda_len, exp_q.pop_front());
                sda_len = 0;
            end
        end
    end

    task automatic wait_idle();
        int guard = 0;
        while ((ack_active || stop_active) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_ack(input logic v, input int n, input int s);
        stretch_cycles = s;
        @(negedge clk);
        ack_req = 1'b1; ack_bit = v;
        if (!v) exp_q.push_back(2*n + 1 + s);
        @(negedge clk);
        ack_req = 1'b0;
        chk("R2 scl pulled at start", scl_pull, 1);
        chk("R2 sda equals inverted ack bit", sda_pull, !v);
        chk("R2 ack_active set", ack_active, 1);
        wait_idle();
        stretch_cycles = 0;
        chk("R4 irq set at end", irq_flag, 1);
        chk("R4 sda released at end", sda_pull, 0);
        chk("R4 scl held low at end", scl_pull, 1);
    endtask

    task automatic run_stop(input int n, input int s, input bit timed);
        int c = 0, c_seen = 0, c_end = 0;
        stretch_cycles = s;
        @(negedge clk);
        stop_req = 1'b1;
        exp_q.push_back(2*n + 2 + s);
        @(negedge clk);
        stop_req = 1'b0;
        c = 1;
        chk("R5 both lines pulled at start", {scl_pull, sda_pull}, 3);
        chk("R8 stop_seen cleared at start", stop_seen, 0);
        while (stop_active && c < 2000) begin
            @(negedge clk);
            c++;
            if (stop_seen && c_seen == 0) c_seen = c;
        end
        c_end = c;
        stretch_cycles = 0;
        if (timed) begin
            chk("R6 stop_seen edge", c_seen, 2*n + 4);
            chk("R6 stop end edge", c_end, 3*n + 4);
        end
        chk("R6 stop_seen after stop", stop_seen, 1);
        chk("R6 irq after stop", irq_flag, 1);
        chk("R6 lines released after stop", {scl_pull, sda_pull}, 0);
    endtask

    task automatic clear_flags();
        @(negedge clk); irq_clr = 1'b1; wcol_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0; wcol_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 flags", {irq_flag, wcol_flag, stop_seen}, 0);
        chk("R1 active", {ack_active, stop_active}, 0);
        chk("R1 buffer", buf_rdata, 0);

        // R7 idle write
        buf_wdata = 8'hA5; buf_wr = 1'b1;
        @(negedge clk); buf_wr = 1'b0;
        chk("R7 idle write loads buffer", buf_rdata, 8'hA5);

        // ACK N=4, write collision mid-sequence
        fork
            run_ack(1'b0, 4, 0);
            begin
                repeat (3) @(negedge clk);
                buf_wdata = 8'h3C; buf_wr = 1'b1;
                @(negedge clk); buf_wr = 1'b0;
                chk("R7 wcol on busy write", wcol_flag, 1);
                chk("R7 buffer unchanged", buf_rdata, 8'hA5);
            end
        join
        repeat (5) @(negedge clk);
        chk("R8 irq sticky", irq_flag, 1);
        chk("R8 wcol sticky", wcol_flag, 1);
        clear_flags();
        chk("R8 flags cleared", {irq_flag, wcol_flag}, 0);

        // ACK with stretch 3, stop request ignored while busy (R9)
        fork
            run_ack(1'b0, 4, 3);
            begin
                repeat (2) @(negedge clk);
                stop_req = 1'b1;
                @(negedge clk); stop_req = 1'b0;
            end
        join
        repeat (4) @(negedge clk);
        chk("R9 busy stop request ignored", {stop_active, sda_pull}, 0);
        clear_flags();

        // NACK
        run_ack(1'b1, 4, 0);
        clear_flags();

        // Stop, timed
        run_stop(4, 0, 1'b1);
        clear_flags();

        // New sequence clears stop_seen, both requests at once: ack wins
        @(negedge clk);
        ack_req = 1'b1; stop_req = 1'b1; ack_bit = 1'b0;
        exp_q.push_back(9);
        @(negedge clk);
        ack_req = 1'b0; stop_req = 1'b0;
        chk("R8 stop_seen cleared by new ack", stop_seen, 0);
        chk("R9 ack wins priority", {ack_active, stop_active}, 2);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R9 no stop after simultaneous requests", stop_active, 0);
        clear_flags();

        // R10 zero reload
        baud_reload = 8'd0;
        run_ack(1'b0, 1, 0);
        clear_flags();
        run_stop(1, 0, 1'b1);
        clear_flags();

        // Stop with stretch
        baud_reload = 8'd4;
        run_ack(1'b0, 4, 0);
        clear_flags();
        run_stop(4, 2, 1'b0);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule